// File: doc/BRIEF.md
# External Memory Bus Master Controller

This block sits between a processor core and an external memory bus. The core hands it one read or write request at a time through a valid/ready handshake. The controller then runs one cycle on the external bus. It decodes the address into one of four active-low bank selects. It drives active-low read and write strobes. It places the operand on the byte lanes of a 48-bit data bus that suit the operand's width. When the access ends, it returns a one-cycle done pulse and, for reads, the data right-justified.

Each access has two phases. In the address phase the address, the bank select and the early write indication are driven. In the strobe phase the read or write strobe is active. The strobe phase lasts at least a programmable minimum number of wait cycles, and is then extended for as long as the external acknowledge input stays low. A conditional access whose condition is false still runs its address phase, including the bank select and any early write indication, but it never strobes. This lets an external synchronous device drop the write it was warned about. A page tracker raises a flag when a bank 0 access lands in a different DRAM page from the previous bank 0 access.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, all four bank selects, the read strobe, the write strobe and the early write select are high, the page flag and done are low, and `req_ready` is high.
- R2: With offset = address minus `EXT_BASE` (default 0x0040_0000), the bank index is offset shifted right by `cfg_bank_bits`. Bank n drives `bus_ms_n[n]` low. Addresses below the base, or with an index of 4 or more, select no bank. The select is held through the address and strobe phases together with `bus_addr`, and all selects are high outside an access.
- R3: An access with `req_cond` low runs a single address-phase cycle with its bank select active and no read or write strobe. Done follows in the next cycle, with `rdata` zero.
- R4: Write lanes follow `req_width`, with unused lanes driven to zero. Code 0 (32-bit word) puts `wdata[31:0]` on bits 47:16. Code 1 (40-bit extended) puts `wdata[39:0]` on bits 47:8. Code 2 (16-bit short) puts `wdata[15:0]` on bits 31:16. Code 3 behaves as code 0.
- R5: Read data comes from the same lanes as in R4, zero-extended and right-justified on `rdata`. It is captured at the clock edge that ends the strobe phase.
- R6: For writes, `bus_sw_n` is low through the address and strobe phases. It is high for reads. A write with a false condition shows `bus_sw_n` low with no `bus_wr_n` pulse.
- R7: The strobe phase lasts at least `cfg_min_wait`+1 cycles, whatever the acknowledge input does.
- R8: The strobe phase ends at the first strobe cycle j (counted from 0) for which j is at least `cfg_min_wait` and `bus_ack` is high at the rising edge that ends that cycle.
- R9: `bus_page` is high during an access only if it selects bank 0 and its page number (address shifted right by `cfg_page_bits`) differs from the page number of the last bank 0 access. The first bank 0 access after reset always counts as a crossing.
- R10: `req_ready` is high only when no access is open. `done` is a single-cycle pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank_bits | input | 5 | log2 of bank size in address units |
| cfg_page_bits | input | 4 | log2 of DRAM page size |
| cfg_min_wait | input | 4 | Minimum wait cycles in the strobe phase |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cond | input | 1 | Condition result; 0 = address phase only |
| req_width | input | 2 | Operand width code (see R4) |
| req_addr | input | 32 | Access address |
| req_wdata | input | 40 | Write operand, right-justified |
| done | output | 1 | Access complete pulse |
| rdata | output | 40 | Read data, right-justified |
| bus_addr | output | 32 | External address |
| bus_ms_n | output | 4 | Active-low bank selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_sw_n | output | 1 | Active-low early write select |
| bus_page | output | 1 | DRAM page crossing flag |
| bus_dout | output | 48 | Write data lanes |
| bus_din | input | 48 | Read data lanes |
| bus_ack | input | 1 | Acknowledge; low adds wait states |

## Verification
Stimulus mixes a fixed-seed random stream of reads and writes with directed cases. The random stream varies width codes, bank size, page size, minimum wait and acknowledge-low runs, and every cycle is compared with a bench model. The width patterns separate correct lane placement from shifted or overlapping lanes. Addresses just below the base and just past bank 3 separate a bounded decode from a wrapping one. Minimum-wait runs with an immediate acknowledge are set against long acknowledge-low runs with zero minimum wait, which separates the wait counter from acknowledge sampling. Repeated, changed and non-bank-0 page sequences show whether the page tracker compares against the right history.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    WD_FIX32   = 2'd0,
    WD_EXT40   = 2'd1,
    WD_SHORT16 = 2'd2,
    WD_RSV     = 2'd3
  } ebc_width_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2
  } ebc_state_e;
endpackage

// File: rtl/ebc_bank_decode.sv
module ebc_bank_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          BANKS    = 4,
  parameter int          BB_W     = 5,
  parameter logic [31:0] EXT_BASE = 32'h0040_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BB_W-1:0]   bank_bits,
  output logic [BANKS-1:0]  sel
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] idx;
  logic              above;

  always_comb begin
    above  = (addr >= EXT_BASE[ADDR_W-1:0]);
    offset = addr - EXT_BASE[ADDR_W-1:0];
    idx    = offset >> bank_bits;
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_sel
    assign sel[g] = above && (idx == ADDR_W'(g));
  end
endmodule

// File: rtl/ebc_lane_map.sv
module ebc_lane_map
  import ebc_pkg::*;
#(
  parameter int BUS_W = 48,
  parameter int OP_W  = 40
) (
  input  ebc_width_e        width,
  input  logic [OP_W-1:0]   wdata,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic [OP_W-1:0]   rdata
);
  always_comb begin
    dout  = '0;
    rdata = '0;
    unique case (width)
      WD_EXT40: begin
        dout[47:8]   = wdata[39:0];
        rdata[39:0]  = din[47:8];
      end
      WD_SHORT16: begin
        dout[31:16]  = wdata[15:0];
        rdata[15:0]  = din[31:16];
      end
      default: begin
        dout[47:16]  = wdata[31:0];
        rdata[31:0]  = din[47:16];
      end
    endcase
  end
endmodule

// File: rtl/ebc_page_track.sv
module ebc_page_track #(
  parameter int ADDR_W = 32,
  parameter int PB_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PB_W-1:0]   page_bits,
  input  logic              bank0,
  input  logic              upd,
  output logic              crossing
);
  logic [ADDR_W-1:0] last_q, last_d;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] pg;
  logic              en;

  always_comb begin
    pg       = addr >> page_bits;
    crossing = bank0 && (!vld_q || (pg != last_q));
    en       = upd && bank0;
    last_d   = pg;
    vld_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      vld_q  <= 1'b0;
    end else if (en) begin
      last_q <= last_d;
      vld_q  <= vld_d;
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cond,
  input  logic              ack,
  input  logic [WAIT_W-1:0] min_wait,
  output logic              in_addr,
  output logic              in_strb,
  output logic              idle,
  output logic              finish,
  output logic              done
);
  ebc_state_e        st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              done_d;
  logic              cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_ADDR;
      ST_ADDR: begin
        if (!cond) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d   = ST_STRB;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_STRB: begin
        if ((cnt_q >= min_wait) && ack) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else if (cnt_q != {WAIT_W{1'b1}}) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    done_d  = finish;
    in_addr = (st_q == ST_ADDR);
    in_strb = (st_q == ST_STRB);
    idle    = (st_q == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  cond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_addr && !cond) |=> (idle && done));
  // R7
  min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strb && (cnt_q < min_wait)) |=> in_strb);
  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strb && !ack) |=> in_strb);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          BUS_W    = 48,
  parameter int          OP_W     = 40,
  parameter int          BANKS    = 4,
  parameter int          WAIT_W   = 4,
  parameter int          BB_W     = 5,
  parameter int          PB_W     = 4,
  parameter logic [31:0] EXT_BASE = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BB_W-1:0]   cfg_bank_bits,
  input  logic [PB_W-1:0]   cfg_page_bits,
  input  logic [WAIT_W-1:0] cfg_min_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cond,
  input  logic [1:0]        req_width,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OP_W-1:0]   req_wdata,
  output logic              done,
  output logic [OP_W-1:0]   rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BANKS-1:0]  bus_ms_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_sw_n,
  output logic              bus_page,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic [BUS_W-1:0]  bus_din,
  input  logic              bus_ack
);
  logic              rs_meta, rs_n;
  logic              accept;
  logic              l_wr, l_cond;
  ebc_width_e        l_width;
  logic [ADDR_W-1:0] l_addr;
  logic [OP_W-1:0]   l_wdata;
  logic              in_addr, in_strb, idle, finish, active;
  logic [BANKS-1:0]  sel;
  logic [BUS_W-1:0]  packed_dout;
  logic [OP_W-1:0]   unpacked_rd, rdata_d;
  logic              crossing;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign accept = req_valid && idle;

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      l_wr    <= 1'b0;
      l_cond  <= 1'b0;
      l_width <= WD_FIX32;
      l_addr  <= '0;
      l_wdata <= '0;
    end else if (accept) begin
      l_wr    <= req_write;
      l_cond  <= req_cond;
      l_width <= ebc_width_e'(req_width);
      l_addr  <= req_addr;
      l_wdata <= req_wdata;
    end
  end

  ebc_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rs_n), .start(accept), .cond(l_cond), .ack(bus_ack),
    .min_wait(cfg_min_wait), .in_addr(in_addr), .in_strb(in_strb),
    .idle(idle), .finish(finish), .done(done)
  );

  ebc_bank_decode #(.ADDR_W(ADDR_W), .BANKS(BANKS), .BB_W(BB_W),
                    .EXT_BASE(EXT_BASE)) u_dec (
    .addr(l_addr), .bank_bits(cfg_bank_bits), .sel(sel)
  );

  ebc_lane_map #(.BUS_W(BUS_W), .OP_W(OP_W)) u_lane (
    .width(l_width), .wdata(l_wdata), .din(bus_din),
    .dout(packed_dout), .rdata(unpacked_rd)
  );

  ebc_page_track #(.ADDR_W(ADDR_W), .PB_W(PB_W)) u_page (
    .clk(clk), .rst_n(rs_n), .addr(l_addr), .page_bits(cfg_page_bits),
    .bank0(sel[0]), .upd(finish), .crossing(crossing)
  );

  always_comb begin
    active    = in_addr || in_strb;
    req_ready = idle;
    bus_addr  = active ? l_addr : '0;
    bus_ms_n  = active ? ~sel : {BANKS{1'b1}};
    bus_sw_n  = !(active && l_wr);
    bus_rd_n  = !(in_strb && !l_wr);
    bus_wr_n  = !(in_strb && l_wr);
    bus_dout  = (active && l_wr) ? packed_dout : '0;
    bus_page  = active && crossing;
    rdata_d   = (in_strb && !l_wr) ? unpacked_rd : '0;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)       rdata <= '0;
    else if (finish) rdata <= rdata_d;
  end

  // R2
  ms_onehot_chk: assert property (@(posedge clk) disable iff (!rs_n)
    $onehot0(~bus_ms_n));
  // R2
  ms_idle_chk: assert property (@(posedge clk) disable iff (!rs_n)
    req_ready |-> (&bus_ms_n));
  // R6
  wr_needs_sw_chk: assert property (@(posedge clk) disable iff (!rs_n)
    !bus_wr_n |-> !bus_sw_n);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rs_n)
    !(!bus_rd_n && !bus_wr_n));
  // R9
  page_bank0_chk: assert property (@(posedge clk) disable iff (!rs_n)
    bus_page |-> !bus_ms_n[0]);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> !done);
endmodule

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk, rst_n;
  logic [4:0]  cfg_bank_bits;
  logic [3:0]  cfg_page_bits, cfg_min_wait;
  logic        req_valid, req_ready, req_write, req_cond;
  logic [1:0]  req_width;
  logic [31:0] req_addr;
  logic [39:0] req_wdata;
  logic        done;
  logic [39:0] rdata;
  logic [31:0] bus_addr;
  logic [3:0]  bus_ms_n;
  logic        bus_rd_n, bus_wr_n, bus_sw_n, bus_page;
  logic [47:0] bus_dout, bus_din;
  logic        bus_ack;

  int n_vec = 0;
  int n_bad = 0;
  bit m_vld = 0;
  logic [31:0] m_last = '0;

  ext_bus_ctrl i_ext_bus_ctrl (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bank(input logic [31:0] a, input logic [4:0] bb);
    logic [31:0] ix;
    if (a < BASE) return -1;
    ix = (a - BASE) >> bb;
    return (ix < 4) ? int'(ix) : -1;
  endfunction

  function automatic logic [3:0] exp_ms(input int b);
    logic [3:0] m = 4'hF;
    if (b >= 0) m[b] = 1'b0;
    return m;
  endfunction

  function automatic logic [47:0] exp_dout(input logic [1:0] w, input logic [39:0] d);
    case (w)
      2'd1:    return {d[39:0], 8'h0};
      2'd2:    return {16'h0, d[15:0], 16'h0};
      default: return {d[31:0], 16'h0};
    endcase
  endfunction

  function automatic logic [39:0] exp_rd(input logic [1:0] w, input logic [47:0] d);
    case (w)
      2'd1:    return d[47:8];
      2'd2:    return {24'h0, d[31:16]};
      default: return {8'h0, d[47:16]};
    endcase
  endfunction

  task automatic access(input bit wr, input bit cnd, input logic [31:0] a,
                        input logic [1:0] w, input logic [39:0] wd, input int ack_lows);
    int b, jend;
    logic [3:0] ems;
    logic [47:0] edo, last_din;
    bit epg;
    b    = exp_bank(a, cfg_bank_bits);
    ems  = exp_ms(b);
    edo  = wr ? exp_dout(w, wd) : 48'h0;
    epg  = (b == 0) && (!m_vld || ((a >> cfg_page_bits) != m_last));
    chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1; req_write = wr; req_cond = cnd; req_addr = a;
    req_width = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    // address phase
    chk(req_ready == 1'b0, "R10 ready low in access", 64'(req_ready), 64'd0);
    chk(bus_ms_n == ems && bus_addr == a, "R2 select in address phase",
        {28'h0, bus_ms_n, bus_addr}, {28'h0, ems, a});
    chk(bus_sw_n == !wr, "R6 early write select", 64'(bus_sw_n), 64'(!wr));
    chk(bus_rd_n && bus_wr_n, "R3 no strobe in address phase",
        64'({bus_rd_n, bus_wr_n}), 64'd3);
    chk(bus_page == epg, "R9 page flag address phase", 64'(bus_page), 64'(epg));
    chk(bus_dout == edo, "R4 write lanes", 64'(bus_dout), 64'(edo));
    bus_ack = (ack_lows == 0);
    last_din = '0;
    if (!cnd) begin
      @(negedge clk);
      chk(done && rdata == 0 && bus_ms_n == 4'hF && bus_rd_n && bus_wr_n,
          "R3 false condition completes", {23'h0, done, rdata}, {23'h0, 1'b1, 40'h0});
    end else begin
      jend = (int'(cfg_min_wait) > ack_lows) ? int'(cfg_min_wait) : ack_lows;
      for (int j = 0; j <= jend; j++) begin
        @(negedge clk);
        chk(bus_rd_n == wr && bus_wr_n == !wr && !done,
            "R7 R8 strobe held", 64'({bus_rd_n, bus_wr_n, done}),
            64'({wr, !wr, 1'b0}));
        chk(bus_ms_n == ems && bus_sw_n == !wr && bus_page == epg,
            "R2 R6 R9 held in strobe", 64'({bus_ms_n, bus_sw_n, bus_page}),
            64'({ems, !wr, epg}));
        if (wr) chk(bus_dout == edo, "R4 write lanes in strobe", 64'(bus_dout), 64'(edo));
        bus_din  = {$urandom(), $urandom()};
        last_din = bus_din;
        bus_ack  = (j >= ack_lows);
      end
      @(negedge clk);
      chk(done && bus_rd_n && bus_wr_n && bus_ms_n == 4'hF,
          "R8 completes on ack", 64'({done, bus_rd_n, bus_wr_n, bus_ms_n}),
          64'({1'b1, 1'b1, 1'b1, 4'hF}));
      if (!wr) chk(rdata == exp_rd(w, last_din), "R5 read lanes",
                   64'(rdata), 64'(exp_rd(w, last_din)));
    end
    if (b == 0) begin m_vld = 1; m_last = a >> cfg_page_bits; end
    bus_ack = 1;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; req_valid = 0; req_write = 0; req_cond = 1; req_width = 0;
    req_addr = 0; req_wdata = 0; bus_din = 0; bus_ack = 1;
    cfg_bank_bits = 5'd16; cfg_page_bits = 4'd8; cfg_min_wait = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk(bus_ms_n == 4'hF && bus_rd_n && bus_wr_n && bus_sw_n && !bus_page &&
        !done && req_ready, "R1 reset state",
        64'({bus_ms_n, bus_rd_n, bus_wr_n, bus_sw_n, bus_page, done, req_ready}),
        64'({4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}));
    // R9 first bank0 access, same page, new page, other bank
    access(0, 1, BASE + 32'h10, 0, 0, 0);
    access(0, 1, BASE + 32'h20, 0, 0, 0);
    access(1, 1, BASE + 32'h340, 0, 40'h12345678, 0);
    access(0, 1, BASE + 32'h0001_0000, 0, 0, 0);
    access(0, 1, BASE + 32'h344, 0, 0, 0);
    // R4 R5 each width
    for (int w = 0; w < 4; w++) begin
      access(1, 1, BASE + 32'h0002_0000, 2'(w), 40'hA5_C3F0_1E69, 0);
      access(0, 1, BASE + 32'h0002_0004, 2'(w), 0, 1);
    end
    // R2 boundaries: below base, each bank, beyond bank 3
    access(0, 1, BASE - 1, 0, 0, 0);
    for (int b = 0; b < 4; b++) access(0, 1, BASE + (32'(b) << 16) + 32'hFFFF, 0, 0, 0);
    access(0, 1, BASE + (32'd4 << 16), 0, 0, 0);
    // R3 R6 false condition: read and aborted write
    access(0, 0, BASE + 32'h0003_0000, 0, 0, 0);
    access(1, 0, BASE + 32'h0003_0000, 1, 40'hFF_FFFF_FFFF, 2);
    // R7 minimum wait with immediate ack; R8 ack held low with zero wait
    cfg_min_wait = 4'd5;
    access(0, 1, BASE + 32'h100, 2, 0, 0);
    cfg_min_wait = 4'd0;
    access(1, 1, BASE + 32'h100, 1, 40'h01_0203_0405, 3);
    cfg_min_wait = 4'd2;
    access(0, 1, BASE + 32'h104, 0, 0, 6);
    // random
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      cfg_bank_bits = 5'(12 + $urandom_range(0, 8));
      cfg_page_bits = 4'($urandom_range(2, 12));
      cfg_min_wait  = 4'($urandom_range(0, 4));
      a = BASE - 32'h40 + ($urandom() % ((32'd5 << cfg_bank_bits) + 32'h80));
      if ($urandom_range(0, 2) == 0) a = BASE + ($urandom() % 32'h2000);
      access($urandom_range(0, 1) == 1, $urandom_range(0, 5) != 0, a,
             2'($urandom_range(0, 3)), {$urandom(), $urandom()} , $urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule